// File: doc/BRIEF.md
# Memory Card SPI-Mode Start-Up Sequencer

This block brings a removable flash memory card from power-up to a ready state on a SPI link. It does not shift bits itself. It drives a neighbouring command engine through a request port and reads back the engine's answer. A request names either a run of idle fill bytes, sent with the card deselected, or a command. A command request carries a 6-bit index, a 32-bit argument and a flag that asks the engine to send the application-command prefix first. The engine answers with the first response byte, the four tail bytes that follow it when there are any, and a flag that marks a missing response.

After a `start` pulse the sequencer runs these steps in order:
- wake-up fill bytes;
- the reset command, retried a bounded number of times;
- the interface-condition check;
- a voltage-window read of the operating-conditions register;
- the repeated operating-condition command, bounded in clock cycles;
- a capacity read, for second-generation cards only;
- a block-length command.

It then reports either the card generation and capacity class with `done`, or a coded reason with `failed`. It also tells the clock generator which SPI clock divider to use. The slow divider stays in force until the card has been fully prepared.

Top module: `sdinit_seq`

## Requirements
- R1: After `start`, exactly WAKE_BYTES requests with `reqFill`=1 are issued before the first command request. Every request (`reqValid`) is a single-cycle pulse, and the next request waits for `rspValid`.
- R2: Command 0 is sent with argument 0. Any answer other than a present response byte of exactly 8'h01 causes a resend, up to RESET_TRIES sends in total. When all tries fail, the run ends failed with `errCode`=1 (no device).
- R3: Command 8 is then sent with argument 32'h1AA. If response bit 2 (illegal command) is set, the card is taken as first generation and the sequence continues. Otherwise the tail's low 12 bits must equal 12'h1AA, or the run fails with `errCode`=2 (unusable).
- R4: Command 58 is sent with argument 0. If tail bit 20 is clear, the run fails with `errCode`=2.
- R5: Command 41 is sent with `reqApp`=1. Its argument has bit 30 set for a second-generation card and is 0 otherwise. It is resent while response bit 0 is 1.
- R6: If bit 0 is still 1 after ACMD_LIMIT clock cycles spent in the command-41 phase, the run fails with `errCode`=3 (timeout). A response with bit 0 clear that is not 8'h00 fails the run with `errCode`=2.
- R7: A second-generation card gets a second command 58. Tail bit 30 set gives `cardType`=3 (high capacity); clear gives `cardType`=2. A first-generation card gets `cardType`=1.
- R8: The last command is 16 with argument BLOCK_LEN (512). A nonzero response fails the run with `errCode`=2.
- R9: `sckDiv` equals ceil(SRC_HZ/INIT_HZ) and `fastClk` is 0 until command 16 succeeds. After that, `sckDiv` equals ceil(SRC_HZ/min(XFER_HZ, 25 MHz)) and `fastClk` is 1.
- R10: A missing response (`rspNone`=1) to any command other than command 0 fails the run with `errCode`=1.
- R11: `done` and `failed` are never both 1. On success, `errCode`=0. On failure, `cardType`=0 (unknown) and `fastClk`=0. Both flags hold until the next `start`.
- R12: After reset, `reqValid`, `done`, `failed`, `fastClk`, `errCode` and `cardType` are 0, and `sckDiv` holds the slow value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a start-up run (taken when not busy) |
| reqValid | output | 1 | One-cycle request to the command engine |
| reqFill | output | 1 | Request is one idle fill byte with the card deselected |
| reqIndex | output | 6 | Command index |
| reqArg | output | 32 | Command argument |
| reqApp | output | 1 | Engine prefixes the application-command escape |
| rspValid | input | 1 | Engine answer strobe |
| rspNone | input | 1 | No response byte arrived |
| rspR1 | input | 8 | First response byte |
| rspTail | input | 32 | Tail bytes of a long response |
| fastClk | output | 1 | Transfer clock selected |
| sckDiv | output | 8 | SPI clock divider to use |
| done | output | 1 | Run succeeded |
| failed | output | 1 | Run failed |
| errCode | output | 2 | 0 none, 1 no device, 2 unusable, 3 timeout |
| cardType | output | 2 | 0 unknown, 1 first generation, 2 standard capacity, 3 high capacity |

## Verification
The bench keeps the defaults of ten wake bytes and five reset tries, so the full retry budget, including its exhaustion, is reached by withholding up to six reset answers. ACMD_LIMIT is lowered to 200 cycles. This puts the command-41 timeout within reach of a card model that stays busy, while a card busy for a handful of rounds still finishes well inside the window. The clock figures stay at 100 MHz source, 400 kHz init and 50 MHz requested transfer, so the 25 MHz cap is exercised and gives dividers of 250 and 4.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  typedef enum logic [1:0] {
    CARD_UNKNOWN = 2'd0,
    CARD_V1      = 2'd1,
    CARD_V2SC    = 2'd2,
    CARD_V2HC    = 2'd3
  } card_t;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_NODEV    = 2'd1,
    ERR_UNUSABLE = 2'd2,
    ERR_TIMEOUT  = 2'd3
  } err_t;

  typedef enum logic [2:0] {
    STEP_RST  = 3'd0,
    STEP_IFC  = 3'd1,
    STEP_OCR  = 3'd2,
    STEP_OPC  = 3'd3,
    STEP_CAP  = 3'd4,
    STEP_BLEN = 3'd5
  } step_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic  clrAll;
    logic  fillInc;
    logic  tryInc;
    logic  timerRun;
    logic  setV2;
    logic  typeLoad;
    card_t typeVal;
    logic  errLoad;
    err_t  errVal;
    logic  fastLoad;
  } ctrl_strobe_t;

  localparam logic [5:0]  IDX_RESET   = 6'd0;
  localparam logic [5:0]  IDX_IFCOND  = 6'd8;
  localparam logic [5:0]  IDX_BLKLEN  = 6'd16;
  localparam logic [5:0]  IDX_OPCOND  = 6'd41;
  localparam logic [5:0]  IDX_READOCR = 6'd58;
  localparam logic [11:0] IFC_PATTERN = 12'h1AA;
  localparam int          OCR_VOLT_BIT = 20;
  localparam int          OCR_CAP_BIT  = 30;
  localparam int          FAST_CAP_HZ  = 25_000_000;

endpackage

// File: rtl/sdinit_dpath.sv
module sdinit_dpath
  import sdinit_pkg::*;
#(
  parameter int WAKE_BYTES  = 10,
  parameter int RESET_TRIES = 5,
  parameter int ACMD_LIMIT  = 100000,
  parameter int BLOCK_LEN   = 512,
  parameter int SRC_HZ      = 100_000_000,
  parameter int INIT_HZ     = 400_000,
  parameter int XFER_HZ     = 50_000_000,
  parameter int DIV_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strobe_t     strb,
  input  step_t            step,
  input  logic [31:0]      rspTail,
  output logic             fillLast,
  output logic             tryLast,
  output logic             timerExpired,
  output logic             isV2,
  output logic             echoOk,
  output logic             voltOk,
  output logic             ccsSet,
  output logic [5:0]       reqIndex,
  output logic [31:0]      reqArg,
  output logic             reqApp,
  output logic             fastClk,
  output logic [DIV_W-1:0] sckDiv,
  output logic [1:0]       cardType,
  output logic [1:0]       errCode
);

  localparam int FILL_W   = $clog2(WAKE_BYTES + 1);
  localparam int TRY_W    = $clog2(RESET_TRIES + 1);
  localparam int TMR_W    = $clog2(ACMD_LIMIT + 1);
  localparam int CAP_HZ   = (XFER_HZ > FAST_CAP_HZ) ? FAST_CAP_HZ : XFER_HZ;
  localparam int SLOW_DIV = (SRC_HZ + INIT_HZ - 1) / INIT_HZ;
  localparam int FAST_DIV = (SRC_HZ + CAP_HZ - 1) / CAP_HZ;

  logic [FILL_W-1:0] fillCnt;
  logic [TRY_W-1:0]  tryCnt;
  logic [TMR_W-1:0]  timer;
  logic              v2Q;
  card_t             typeQ;
  err_t              errQ;
  logic              fastQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt <= '0;
      tryCnt  <= '0;
      timer   <= '0;
      v2Q     <= 1'b0;
      typeQ   <= CARD_UNKNOWN;
      errQ    <= ERR_NONE;
      fastQ   <= 1'b0;
    end else if (strb.clrAll) begin
      fillCnt <= '0;
      tryCnt  <= '0;
      timer   <= '0;
      v2Q     <= 1'b0;
      typeQ   <= CARD_UNKNOWN;
      errQ    <= ERR_NONE;
      fastQ   <= 1'b0;
    end else begin
      if (strb.fillInc) fillCnt <= fillCnt + 1'b1;
      if (strb.tryInc)  tryCnt  <= tryCnt + 1'b1;
      if (strb.timerRun && !timerExpired) timer <= timer + 1'b1;
      if (strb.setV2)    v2Q   <= 1'b1;
      if (strb.typeLoad) typeQ <= strb.typeVal;
      if (strb.errLoad)  errQ  <= strb.errVal;
      if (strb.fastLoad) fastQ <= 1'b1;
    end
  end

  assign fillLast     = (fillCnt == FILL_W'(WAKE_BYTES - 1));
  assign tryLast      = (tryCnt == TRY_W'(RESET_TRIES - 1));
  assign timerExpired = (timer == TMR_W'(ACMD_LIMIT));
  assign isV2         = v2Q;

  // response field decode
  assign echoOk = (rspTail[11:0] == IFC_PATTERN);
  assign voltOk = rspTail[OCR_VOLT_BIT];
  assign ccsSet = rspTail[OCR_CAP_BIT];

  // command selection per step
  always_comb begin
    reqIndex = IDX_RESET;
    reqArg   = '0;
    reqApp   = 1'b0;
    unique case (step)
      STEP_RST:  reqIndex = IDX_RESET;
      STEP_IFC: begin
        reqIndex = IDX_IFCOND;
        reqArg   = {20'd0, IFC_PATTERN};
      end
      STEP_OCR, STEP_CAP: reqIndex = IDX_READOCR;
      STEP_OPC: begin
        reqIndex = IDX_OPCOND;
        reqApp   = 1'b1;
        reqArg   = v2Q ? (32'd1 << OCR_CAP_BIT) : 32'd0;
      end
      STEP_BLEN: begin
        reqIndex = IDX_BLKLEN;
        reqArg   = 32'(BLOCK_LEN);
      end
      default: reqIndex = IDX_RESET;
    endcase
  end

  assign fastClk  = fastQ;
  assign sckDiv   = fastQ ? DIV_W'(FAST_DIV) : DIV_W'(SLOW_DIV);
  assign cardType = typeQ;
  assign errCode  = errQ;

endmodule

// File: rtl/sdinit_ctrl.sv
module sdinit_ctrl
  import sdinit_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         rspValid,
  input  logic         rspNone,
  input  logic [7:0]   rspR1,
  input  logic         fillLast,
  input  logic         tryLast,
  input  logic         timerExpired,
  input  logic         isV2,
  input  logic         echoOk,
  input  logic         voltOk,
  input  logic         ccsSet,
  output ctrl_strobe_t strb,
  output step_t        step,
  output logic         reqValid,
  output logic         reqFill,
  output logic         done,
  output logic         failed
);

  typedef enum logic [2:0] {
    S_IDLE, S_FILL_REQ, S_FILL_WAIT, S_CMD_REQ, S_CMD_WAIT
  } state_t;

  state_t stateQ, stateD;
  step_t  stepQ, stepD;
  logic   doneQ, doneD, failQ, failD;
  logic   failNow;
  err_t   failCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      stepQ  <= STEP_RST;
      doneQ  <= 1'b0;
      failQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      stepQ  <= stepD;
      doneQ  <= doneD;
      failQ  <= failD;
    end
  end

  always_comb begin
    stateD   = stateQ;
    stepD    = stepQ;
    doneD    = doneQ;
    failD    = failQ;
    strb     = '0;
    failNow  = 1'b0;
    failCode = ERR_NONE;
    strb.timerRun = (stepQ == STEP_OPC) &&
                    (stateQ == S_CMD_REQ || stateQ == S_CMD_WAIT);

    unique case (stateQ)
      S_IDLE: begin
        if (start) begin
          strb.clrAll = 1'b1;
          doneD  = 1'b0;
          failD  = 1'b0;
          stepD  = STEP_RST;
          stateD = S_FILL_REQ;
        end
      end
      S_FILL_REQ: stateD = S_FILL_WAIT;
      S_FILL_WAIT: begin
        if (rspValid) begin
          if (fillLast) begin
            stateD = S_CMD_REQ;
          end else begin
            strb.fillInc = 1'b1;
            stateD = S_FILL_REQ;
          end
        end
      end
      S_CMD_REQ: stateD = S_CMD_WAIT;
      S_CMD_WAIT: begin
        if (rspValid) begin
          stateD = S_CMD_REQ;
          if (stepQ == STEP_RST) begin
            if (!rspNone && rspR1 == 8'h01) begin
              stepD = STEP_IFC;
            end else if (tryLast) begin
              failNow = 1'b1; failCode = ERR_NODEV;
            end else begin
              strb.tryInc = 1'b1;
            end
          end else if (rspNone) begin
            failNow = 1'b1; failCode = ERR_NODEV;
          end else begin
            unique case (stepQ)
              STEP_IFC: begin
                if (rspR1[2]) begin
                  stepD = STEP_OCR;
                end else if (!echoOk) begin
                  failNow = 1'b1; failCode = ERR_UNUSABLE;
                end else begin
                  strb.setV2 = 1'b1;
                  stepD = STEP_OCR;
                end
              end
              STEP_OCR: begin
                if (!voltOk) begin
                  failNow = 1'b1; failCode = ERR_UNUSABLE;
                end else begin
                  stepD = STEP_OPC;
                end
              end
              STEP_OPC: begin
                if (rspR1[0]) begin
                  if (timerExpired) begin
                    failNow = 1'b1; failCode = ERR_TIMEOUT;
                  end
                end else if (rspR1 != 8'h00) begin
                  failNow = 1'b1; failCode = ERR_UNUSABLE;
                end else if (isV2) begin
                  stepD = STEP_CAP;
                end else begin
                  strb.typeLoad = 1'b1;
                  strb.typeVal  = CARD_V1;
                  stepD = STEP_BLEN;
                end
              end
              STEP_CAP: begin
                strb.typeLoad = 1'b1;
                strb.typeVal  = ccsSet ? CARD_V2HC : CARD_V2SC;
                stepD = STEP_BLEN;
              end
              STEP_BLEN: begin
                if (rspR1 != 8'h00) begin
                  failNow = 1'b1; failCode = ERR_UNUSABLE;
                end else begin
                  strb.fastLoad = 1'b1;
                  doneD  = 1'b1;
                  stateD = S_IDLE;
                end
              end
              default: stateD = S_IDLE;
            endcase
          end
        end
      end
      default: stateD = S_IDLE;
    endcase

    if (failNow) begin
      strb.errLoad  = 1'b1;
      strb.errVal   = failCode;
      strb.typeLoad = 1'b1;
      strb.typeVal  = CARD_UNKNOWN;
      failD  = 1'b1;
      stateD = S_IDLE;
    end
  end

  assign step     = stepQ;
  assign reqValid = (stateQ == S_FILL_REQ) || (stateQ == S_CMD_REQ);
  assign reqFill  = (stateQ == S_FILL_REQ);
  assign done     = doneQ;
  assign failed   = failQ;

endmodule

// File: rtl/sdinit_seq.sv
module sdinit_seq
  import sdinit_pkg::*;
#(
  parameter int WAKE_BYTES  = 10,
  parameter int RESET_TRIES = 5,
  parameter int ACMD_LIMIT  = 100000,
  parameter int BLOCK_LEN   = 512,
  parameter int SRC_HZ      = 100_000_000,
  parameter int INIT_HZ     = 400_000,
  parameter int XFER_HZ     = 50_000_000,
  parameter int DIV_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic             reqValid,
  output logic             reqFill,
  output logic [5:0]       reqIndex,
  output logic [31:0]      reqArg,
  output logic             reqApp,
  input  logic             rspValid,
  input  logic             rspNone,
  input  logic [7:0]       rspR1,
  input  logic [31:0]      rspTail,
  output logic             fastClk,
  output logic [DIV_W-1:0] sckDiv,
  output logic             done,
  output logic             failed,
  output logic [1:0]       errCode,
  output logic [1:0]       cardType
);

  ctrl_strobe_t strb;
  step_t        step;
  logic fillLast, tryLast, timerExpired, isV2, echoOk, voltOk, ccsSet;

  sdinit_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .rspValid(rspValid), .rspNone(rspNone), .rspR1(rspR1),
    .fillLast(fillLast), .tryLast(tryLast), .timerExpired(timerExpired),
    .isV2(isV2), .echoOk(echoOk), .voltOk(voltOk), .ccsSet(ccsSet),
    .strb(strb), .step(step), .reqValid(reqValid), .reqFill(reqFill),
    .done(done), .failed(failed)
  );

  sdinit_dpath #(
    .WAKE_BYTES(WAKE_BYTES), .RESET_TRIES(RESET_TRIES), .ACMD_LIMIT(ACMD_LIMIT),
    .BLOCK_LEN(BLOCK_LEN), .SRC_HZ(SRC_HZ), .INIT_HZ(INIT_HZ),
    .XFER_HZ(XFER_HZ), .DIV_W(DIV_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .step(step), .rspTail(rspTail),
    .fillLast(fillLast), .tryLast(tryLast), .timerExpired(timerExpired),
    .isV2(isV2), .echoOk(echoOk), .voltOk(voltOk), .ccsSet(ccsSet),
    .reqIndex(reqIndex), .reqArg(reqArg), .reqApp(reqApp),
    .fastClk(fastClk), .sckDiv(sckDiv), .cardType(cardType), .errCode(errCode)
  );

endmodule

// File: rtl/sdinit_seq_chk.sv
module sdinit_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [5:0]  reqIndex,
  input logic [31:0] reqArg,
  input logic        reqApp,
  input logic        reqFill,
  input logic        fastClk,
  input logic        done,
  input logic        failed,
  input logic [1:0]  errCode,
  input logic [1:0]  cardType
);

  assert_req_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid);

  assert_reset_arg_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqFill && reqIndex == 6'd0) |-> reqArg == 32'd0);

  assert_ifcond_arg_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqFill && reqIndex == 6'd8) |-> reqArg == 32'h1AA);

  assert_opcond_app_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqFill && reqIndex == 6'd41) |-> (reqApp && reqArg[29:0] == 30'd0));

  assert_blklen_arg_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqFill && reqIndex == 6'd16) |-> reqArg == 32'd512);

  assert_fast_after_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    fastClk |-> done);

  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(done && failed));

  assert_fail_type_R11: assert property (@(posedge clk) disable iff (!rstN)
    failed |-> (cardType == 2'd0 && errCode != 2'd0));

  assert_done_err_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (errCode == 2'd0 && cardType != 2'd0));

  assert_no_req_when_finished_R11: assert property (@(posedge clk) disable iff (!rstN)
    (done || failed) |-> !reqValid);

endmodule

bind sdinit_seq sdinit_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIndex(reqIndex),
  .reqArg(reqArg), .reqApp(reqApp), .reqFill(reqFill), .fastClk(fastClk),
  .done(done), .failed(failed), .errCode(errCode), .cardType(cardType)
);

// File: tb/sdinit_seq_bench.sv
`timescale 1ns/1ps
module sdinit_seq_bench;

  localparam int LIMIT = 200;
  localparam int TRIES = 5;
  localparam int WAKE  = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic reqValid, reqFill, reqApp, fastClk, done, failed;
  logic [5:0]  reqIndex;
  logic [31:0] reqArg;
  logic [7:0]  sckDiv;
  logic [1:0]  errCode, cardType;
  logic        rspValid = 1'b0, rspNone = 1'b0;
  logic [7:0]  rspR1 = 8'hFF;
  logic [31:0] rspTail = '0;

  always #2.5 clk = ~clk;

  sdinit_seq #(.ACMD_LIMIT(LIMIT), .WAKE_BYTES(WAKE), .RESET_TRIES(TRIES)) u_sdinit_seq (
    .clk(clk), .rstN(rstN), .start(start), .reqValid(reqValid), .reqFill(reqFill),
    .reqIndex(reqIndex), .reqArg(reqArg), .reqApp(reqApp), .rspValid(rspValid),
    .rspNone(rspNone), .rspR1(rspR1), .rspTail(rspTail), .fastClk(fastClk),
    .sckDiv(sckDiv), .done(done), .failed(failed), .errCode(errCode), .cardType(cardType)
  );

  int nChecks = 0, nErrors = 0, cycles = 0;
  bit finished = 0;

  // card model knobs
  int lost, c8Mode, busy, lat;
  bit volt, hcs, badFinal, blenBad;
  // observation
  int fillSeen, cmdSeen, cmd0Seen, acmdSeen, argBad;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expErr();
    if (lost >= TRIES) return 1;
    if (c8Mode == 3) return 1;
    if (c8Mode == 2) return 2;
    if (!volt) return 2;
    if (busy >= 1000) return 3;
    if (badFinal) return 2;
    if (blenBad) return 2;
    return 0;
  endfunction

  function automatic int expType();
    if (expErr() != 0) return 0;
    if (c8Mode == 1) return 1;
    return hcs ? 3 : 2;
  endfunction

  // responder: answers each request after lat negative edges
  initial begin
    forever begin
      @(negedge clk);
      rspValid = 1'b0;
      if (reqValid) begin
        rspNone = 1'b0; rspR1 = 8'h00; rspTail = '0;
        if (reqFill) begin
          if (cmdSeen == 0) fillSeen++;
          rspR1 = 8'hFF;
        end else begin
          cmdSeen++;
          case (reqIndex)
            6'd0: begin
              cmd0Seen++;
              if (reqArg != 0) argBad++;
              if (cmd0Seen <= lost) begin
                if (cmd0Seen % 2 == 1) rspNone = 1'b1; else rspR1 = 8'h03;
              end else rspR1 = 8'h01;
            end
            6'd8: begin
              if (reqArg != 32'h1AA) argBad++;
              case (c8Mode)
                0: begin rspR1 = 8'h01; rspTail = 32'h0000_01AA; end
                1: rspR1 = 8'h05;
                2: begin rspR1 = 8'h01; rspTail = 32'h0000_02AA; end
                default: rspNone = 1'b1;
              endcase
            end
            6'd58: begin
              rspTail = {1'b1, (hcs && acmdSeen > busy), 9'd0, volt, 20'd0};
            end
            6'd41: begin
              acmdSeen++;
              if (!reqApp) argBad++;
              if (reqArg != ((c8Mode == 0) ? 32'h4000_0000 : 32'h0)) argBad++;
              if (acmdSeen <= busy) rspR1 = 8'h01;
              else rspR1 = badFinal ? 8'h04 : 8'h00;
            end
            6'd16: begin
              if (reqArg != 32'd512) argBad++;
              rspR1 = blenBad ? 8'h40 : 8'h00;
            end
            default: argBad++;
          endcase
        end
        repeat (lat) @(negedge clk);
        rspValid = 1'b1;
      end
    end
  end

  task automatic runCard(input string tag);
    int w = 0;
    int e = expErr();
    int t = expType();
    fillSeen = 0; cmdSeen = 0; cmd0Seen = 0; acmdSeen = 0; argBad = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!(done || failed) && w < 20000) begin @(negedge clk); w++; end
    @(negedge clk);
    chk({tag, " R11 done"}, done, e == 0);
    chk({tag, " R11 failed"}, failed, e != 0);
    chk({tag, " R2/R3/R4/R6/R8/R10 errCode"}, errCode, e);
    chk({tag, " R7 cardType"}, cardType, t);
    chk({tag, " R9 fastClk"}, fastClk, e == 0);
    chk({tag, " R9 sckDiv"}, sckDiv, (e == 0) ? 4 : 250);
    chk({tag, " R1 wake bytes"}, fillSeen, WAKE);
    chk({tag, " R2 reset sends"}, cmd0Seen, (lost + 1 < TRIES) ? lost + 1 : TRIES);
    chk({tag, " R5 arguments"}, argBad, 0);
  endtask

  task automatic setCard(input int l, input int c8, input bit v, input int b,
                         input bit bf, input bit h, input bit bb);
    lost = l; c8Mode = c8; volt = v; busy = b; badFinal = bf; hcs = h; blenBad = bb;
    lat = 1 + (l % 3);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    setCard(0, 0, 1, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R12 reqValid", reqValid, 0);
    chk("R12 done/failed", {done, failed}, 0);
    chk("R12 errCode/cardType", {errCode, cardType}, 0);
    chk("R12 sckDiv slow", sckDiv, 250);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 idle after release", reqValid, 0);

    setCard(0, 0, 1, 3, 0, 1, 0); runCard("v2 high capacity R7");
    setCard(0, 0, 1, 2, 0, 0, 0); runCard("v2 standard R7");
    setCard(2, 1, 1, 4, 0, 0, 0); runCard("v1 R3 R5");
    setCard(4, 0, 1, 0, 0, 1, 0); runCard("last reset try R2");
    setCard(5, 0, 1, 0, 0, 1, 0); runCard("resets exhausted R2");
    setCard(6, 0, 1, 0, 0, 1, 0); runCard("resets never answered R2");
    setCard(0, 2, 1, 0, 0, 0, 0); runCard("bad echo R3");
    setCard(0, 3, 1, 0, 0, 0, 0); runCard("no answer R10");
    setCard(0, 0, 0, 0, 0, 0, 0); runCard("voltage R4");
    setCard(1, 0, 1, 1000, 0, 0, 0); runCard("timeout R6");
    setCard(0, 1, 1, 1000, 0, 0, 0); runCard("v1 timeout R6");
    setCard(0, 0, 1, 2, 1, 0, 0); runCard("bad final R6");
    setCard(0, 0, 1, 1, 0, 1, 1); runCard("block length R8");

    for (int i = 0; i < 30; i++) begin
      int r = $urandom_range(0, 9);
      setCard($urandom_range(0, 6),
              (r < 6) ? 0 : (r < 8) ? 1 : (r == 8) ? 2 : 3,
              $urandom_range(0, 7) != 0,
              ($urandom_range(0, 9) == 0) ? 1000 : $urandom_range(0, 6),
              $urandom_range(0, 9) == 0,
              $urandom_range(0, 1) == 1,
              $urandom_range(0, 9) == 0);
      lat = $urandom_range(1, 4);
      runCard("random");
    end

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      finished = 1;
      nChecks++; nErrors++;
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule